// File: doc/BRIEF.md
# Tapped Delay Chain

This block feeds an 8-bit sample stream through three delay lines wired in series. Each line has its own length, written by a host into a control register. The output of every line is exposed as a tap that drives one row of a downstream filter, and it is also the input of the next line. The output of the last line goes to a cascade output, which feeds the next device in a chain. A bypass setting sends the raw input to the cascade output through a fixed two-register pipe, so several devices can be chained without programming lengths into each of them.

The stream carries one sample per clock, qualified by a valid strobe. All storage moves forward only on valid cycles, so every delay is counted in samples, not in clocks. Each line stores its data in a circular buffer. The read position sits behind the write position by the programmed length.

Each line contains a small fill tracker that records how much real data it holds since reset. Its states are `FILL_EMPTY`, `FILL_PARTIAL` and `FILL_FULL`, with these transitions:
- EMPTY→PARTIAL on the first valid sample.
- PARTIAL→PARTIAL while fewer than the buffer depth of samples have been written.
- PARTIAL→FULL on the valid sample that fills the buffer.
- FULL→FULL from then on.

While a line is in EMPTY or PARTIAL, a read of a slot that has never been written returns zero.

Top module: `tapped_delay_chain`

## Requirements
- R1: After reset all three lengths are 0 and bypass is off. A line later programmed to length L outputs 0 until L valid samples have entered it since reset.
- R2: A line of length 0 presents its own input on its tap in the same cycle, with no register in the path.
- R3: Line k+1 takes tap k as its input. With bypass off, the cascade output equals the tap of the last line, so the total delay is the sum of the three lengths.
- R4: With bypass on, the cascade output on each valid cycle is the input sample from two valid cycles earlier (0 if there was none since reset). The programmed lengths do not affect the cascade output, and the taps keep working as before.
- R5: A line of length L, for L from 1 to 1120, presents on each valid cycle the sample it received L valid cycles earlier.
- R6: Storage, pointers and the bypass pipe advance only on cycles with `in_valid` high. Data on `in_data` during idle cycles has no effect on later samples.
- R7: A configuration write with `cfg_we` high behaves as follows:
  - `cfg_sel` 0, 1 or 2 sets the length of line 1, 2 or 3 to `cfg_wdata`.
  - `cfg_sel` 3 sets bypass to `cfg_wdata[0]`.
  - A length above 1120 saturates to 1120.
- R8: A new length takes effect on the first sample after the write cycle. If the line already holds enough data, it reads the true history at the new offset.
- R9: `tap_valid` (one bit per line) and `casc_valid` equal `in_valid` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_sel | input | 2 | Register select: 0..2 line lengths, 3 bypass |
| cfg_wdata | input | 11 | Configuration write data |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Input sample |
| tap_data | output | 24 | Line outputs, line k in bits [8k+7:8k] |
| tap_valid | output | 3 | Valid flag per tap |
| casc_data | output | 8 | Cascade output |
| casc_valid | output | 1 | Cascade valid |

## Verification
Some properties are checked by assertions on every cycle:
- length-0 pass-through and tap-to-tap forwarding,
- cascade selection with bypass off,
- the two-sample bypass delay,
- saturation of the length registers,
- output stability across idle cycles,
- the valid flags.

Other behaviours depend on history over many samples, so only the bench's scenarios can show them:
- the exact sample-count delays of programmed lines up to the 1120 maximum,
- zeros read from unwritten storage after reset,
- the sum of delays along the chain,
- reading at a new offset after a length change.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_e;
endpackage

// File: rtl/tdc_cfg_regs.sv
module tdc_cfg_regs #(
    parameter int MAX_LEN   = 1120,
    parameter int NUM_LINES = 3,
    localparam int LEN_W    = $clog2(MAX_LEN + 1),
    localparam int SEL_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  logic [LEN_W-1:0]           wdata,
    output logic [NUM_LINES*LEN_W-1:0] len_flat,
    output logic                       bypass
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_len
        logic [LEN_W-1:0] len_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_q <= '0;
            end else if (we && sel == SEL_W'(i)) begin
                len_q <= (wdata > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : wdata;
            end
        end
        assign len_flat[i*LEN_W +: LEN_W] = len_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bypass <= 1'b0;
        end else if (we && sel == SEL_W'(NUM_LINES)) begin
            bypass <= wdata[0];
        end
    end
endmodule

// File: rtl/tdc_delay_line.sv
module tdc_delay_line
    import tdc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MAX_LEN = 1120,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int PTR_W  = $clog2(MAX_LEN),
    localparam int AW     = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [DATA_W-1:0] din,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [MAX_LEN];
    logic [PTR_W-1:0]  wp;
    logic [LEN_W-1:0]  fill;
    fill_state_e       state, state_n;
    logic [AW-1:0]     wp_x, len_x, rd_x;
    logic [PTR_W-1:0]  rd_idx;

    // storage write, no reset needed: unwritten slots are masked by the fill tracker
    always_ff @(posedge clk) begin
        if (adv) begin
            mem[wp] <= din;
        end
    end

    // state register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FILL_EMPTY;
            wp    <= '0;
            fill  <= '0;
        end else begin
            state <= state_n;
            if (adv) begin
                wp <= (wp == PTR_W'(MAX_LEN - 1)) ? '0 : wp + 1'b1;
                if (state != FILL_FULL) begin
                    fill <= fill + 1'b1;
                end
            end
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            FILL_EMPTY:   if (adv) state_n = FILL_PARTIAL;
            FILL_PARTIAL: if (adv && fill == LEN_W'(MAX_LEN - 1)) state_n = FILL_FULL;
            FILL_FULL:    state_n = FILL_FULL;
            default:      state_n = FILL_EMPTY;
        endcase
    end

    // read position behind the write pointer by the programmed length
    always_comb begin
        wp_x   = AW'(wp);
        len_x  = AW'(len);
        rd_x   = (wp_x >= len_x) ? (wp_x - len_x) : (wp_x + AW'(MAX_LEN) - len_x);
        rd_idx = rd_x[PTR_W-1:0];
    end

    // output logic
    always_comb begin
        dout = '0;
        unique case (state)
            FILL_EMPTY:   dout = (len == '0) ? din : '0;
            FILL_PARTIAL: dout = (len == '0) ? din : ((len > fill) ? '0 : mem[rd_idx]);
            FILL_FULL:    dout = (len == '0) ? din : mem[rd_idx];
            default:      dout = '0;
        endcase
    end
endmodule

// File: rtl/tdc_bypass_pipe.sv
module tdc_bypass_pipe #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[i] <= '0;
            end else if (adv) begin
                stg[i] <= (i == 0) ? din : stg[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/tapped_delay_chain.sv
module tapped_delay_chain #(
    parameter int DATA_W    = 8,
    parameter int MAX_LEN   = 1120,
    parameter int NUM_LINES = 3,
    localparam int LEN_W    = $clog2(MAX_LEN + 1),
    localparam int SEL_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [LEN_W-1:0]            cfg_wdata,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    output logic [NUM_LINES*DATA_W-1:0] tap_data,
    output logic [NUM_LINES-1:0]        tap_valid,
    output logic [DATA_W-1:0]           casc_data,
    output logic                        casc_valid
);
    logic [NUM_LINES*LEN_W-1:0] len_flat;
    logic                       bypass_q;
    logic [DATA_W-1:0]          line_in [NUM_LINES+1];
    logic [DATA_W-1:0]          byp_out;

    tdc_cfg_regs #(.MAX_LEN(MAX_LEN), .NUM_LINES(NUM_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .len_flat(len_flat), .bypass(bypass_q)
    );

    assign line_in[0] = in_data;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        tdc_delay_line #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_line (
            .clk(clk), .rst_n(rst_n), .adv(in_valid),
            .din(line_in[k]), .len(len_flat[k*LEN_W +: LEN_W]),
            .dout(line_in[k+1])
        );
        assign tap_data[k*DATA_W +: DATA_W] = line_in[k+1];
    end

    tdc_bypass_pipe #(.DATA_W(DATA_W), .STAGES(2)) u_byp (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(in_data), .dout(byp_out)
    );

    assign casc_data  = bypass_q ? byp_out : line_in[NUM_LINES];
    assign tap_valid  = {NUM_LINES{in_valid}};
    assign casc_valid = in_valid;
endmodule

// File: rtl/tdc_chain_chk.sv
module tdc_chain_chk #(
    parameter int DATA_W    = 8,
    parameter int MAX_LEN   = 1120,
    parameter int NUM_LINES = 3,
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic                        in_valid,
    input logic [DATA_W-1:0]           in_data,
    input logic [NUM_LINES*DATA_W-1:0] tap_data,
    input logic [NUM_LINES-1:0]        tap_valid,
    input logic [DATA_W-1:0]           casc_data,
    input logic                        casc_valid,
    input logic [NUM_LINES*LEN_W-1:0]  len_flat,
    input logic                        bypass
);
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    a_r2_zero_len_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (len_flat[0 +: LEN_W] == '0) |-> (tap_data[0 +: DATA_W] == in_data));

    for (genvar i = 1; i < NUM_LINES; i++) begin : g_fwd
        a_r3_tap_forward: assert property (@(posedge clk) disable iff (!rst_n)
            (len_flat[i*LEN_W +: LEN_W] == '0) |->
            (tap_data[i*DATA_W +: DATA_W] == tap_data[(i-1)*DATA_W +: DATA_W]));
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sat
        a_r7_len_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            len_flat[i*LEN_W +: LEN_W] <= LEN_W'(MAX_LEN));
    end

    a_r3_casc_last_tap: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (casc_data == tap_data[(NUM_LINES-1)*DATA_W +: DATA_W]));

    a_r4_bypass_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && bypass && in_valid && $past(in_valid) && $past(in_valid, 2))
        |-> (casc_data == $past(in_data, 2)));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !in_valid && !cfg_we) |=>
        (!$stable(in_data) || ($stable(tap_data) && $stable(casc_data))));

    a_r9_valid_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_valid == {NUM_LINES{in_valid}}) && (casc_valid == in_valid));
endmodule

bind tapped_delay_chain tdc_chain_chk #(
    .DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .NUM_LINES(NUM_LINES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_valid(in_valid),
    .in_data(in_data), .tap_data(tap_data), .tap_valid(tap_valid),
    .casc_data(casc_data), .casc_valid(casc_valid),
    .len_flat(len_flat), .bypass(bypass_q)
);

// File: tb/tb_tapped_delay_chain.sv
module tb_tapped_delay_chain;
    localparam int NL   = 3;
    localparam int MAXL = 1120;
    localparam int HD   = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [10:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic [23:0] tap_data;
    logic [2:0]  tap_valid;
    logic [7:0]  casc_data;
    logic        casc_valid;

    tapped_delay_chain dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
        .tap_data(tap_data), .tap_valid(tap_valid),
        .casc_data(casc_data), .casc_valid(casc_valid)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [23:0] exp_tap_q [$];
    logic [7:0]  exp_casc_q [$];
    string       exp_tag_q [$];

    // reference model state
    logic [7:0] mh [NL][HD];
    int         mlen [NL];
    bit         mbyp;
    int         n;
    string      cur_req;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        n = 0; mbyp = 1'b0;
        for (int k = 0; k < NL; k++) mlen[k] = 0;
    endtask

    task automatic cfg_write(input int sel, input int val);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 11'(val);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (sel < NL) mlen[sel] = (val > MAXL) ? MAXL : val;
        else mbyp = val[0];
    endtask

    // driver: computes expectations from the requirements and pushes them
    task automatic send(input logic [7:0] d);
        logic [7:0]  cur;
        logic [23:0] et;
        cur = d;
        for (int k = 0; k < NL; k++) begin
            mh[k][n] = cur;
            cur = (n >= mlen[k]) ? mh[k][n - mlen[k]] : 8'h00;
            et[k*8 +: 8] = cur;
        end
        exp_tap_q.push_back(et);
        exp_casc_q.push_back(mbyp ? ((n >= 2) ? mh[0][n-2] : 8'h00) : et[23:16]);
        exp_tag_q.push_back(cur_req);
        n++;
        in_valid = 1'b1; in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_data = 8'($urandom);
        @(negedge clk);
        check("R9 idle valid", {28'd0, tap_valid, casc_valid}, 32'd0);
        @(posedge clk); #1;
    endtask

    // monitor: pops and compares on valid cycles, away from the active edge
    always @(negedge clk) begin
        if (rst_n && in_valid) begin
            n_cmp++;
            if (exp_tap_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: actual output with no expected item, expected none");
            end else begin
                logic [23:0] et;
                logic [7:0]  ec;
                string       tg;
                et = exp_tap_q.pop_front();
                ec = exp_casc_q.pop_front();
                tg = exp_tag_q.pop_front();
                if (tap_data !== et || casc_data !== ec || tap_valid !== 3'b111 || casc_valid !== 1'b1) begin
                    n_bad++;
                    $display("FAIL %s: actual taps %h casc %h vld %b%b expected taps %h casc %h vld 1111",
                             tg, tap_data, casc_data, tap_valid, casc_valid, et, ec);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung run, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, all lengths zero, bypass off
        do_reset();
        in_data = 8'h5A;
        @(negedge clk);
        check("R1 reset taps", {8'd0, tap_data}, {8'd0, {3{8'h5A}}});
        check("R1 reset casc", {24'd0, casc_data}, 32'h5A);
        @(posedge clk); #1;
        cur_req = "R2 R3 zero-length pass";
        for (int i = 0; i < 5; i++) send(8'($urandom));

        // R5 R3 R6: mixed lengths with idle gaps carrying noise
        do_reset();
        cfg_write(0, 3); cfg_write(1, 0); cfg_write(2, 5);
        cur_req = "R5 R3 R6 mixed lengths";
        for (int i = 0; i < 40; i++) begin
            send(8'(i * 7 + 1));
            if (i % 5 == 2) idle();
        end

        // R4: bypass with programmed lengths
        do_reset();
        cfg_write(0, 2); cfg_write(1, 4); cfg_write(2, 1); cfg_write(3, 1);
        cur_req = "R4 bypass";
        for (int i = 0; i < 20; i++) begin
            send(8'($urandom));
            if (i == 9) idle();
        end

        // R7 R1 R5: saturating write, maximum length, zeros before fill
        do_reset();
        cfg_write(0, 2000);
        cur_req = "R7 R1 R5 max length";
        for (int i = 0; i < MAXL + 12; i++) send(8'(i ^ (i >> 3)));

        // R8: length change mid-stream
        do_reset();
        cfg_write(0, 2); cfg_write(1, 1); cfg_write(2, 1);
        cur_req = "R8 before change";
        for (int i = 0; i < 10; i++) send(8'(8'h30 + i));
        cfg_write(0, 4);
        cur_req = "R8 after change";
        for (int i = 0; i < 10; i++) send(8'(8'h60 + i));
        cfg_write(3, 1);
        cur_req = "R8 R4 bypass switched on";
        for (int i = 0; i < 4; i++) send(8'(8'h90 + i));

        @(negedge clk);
        check("R6 scoreboard drained", 32'(exp_tap_q.size()), 32'd0);
        summary();
        $finish;
    end
endmodule